// File: doc/BRIEF.md
# Eight-Channel Counter-Capture TDC with Serial Readout

This block measures when hits arrive. A single free-running 9-bit synchronous counter runs on the counting clock. Each of eight hit inputs is synchronised to that clock. On a rising edge the channel stores the current count as its timestamp. One counter wrap covers one bunch-crossing interval, so the timestamp is the arrival phase within that interval.

Each stored timestamp crosses into a separate readout clock domain through a per-channel request/acknowledge handshake. The receiving side always holds a complete value, never a partial one. In the readout domain every channel has a 9-bit parallel-in serial-out register on its own serial line. A single mode input drives all of these registers. At a readout edge with mode 0, every register loads its channel's latest delivered timestamp. At edges with mode 1, the registers shift out one bit per edge, most significant bit first, and a frame-valid output marks the nine data cycles.

Each channel keeps a pending flag. A capture sets it, and a load that has taken the captured value clears it. A hit that arrives while an earlier value is still waiting to be read replaces that value and raises a sticky per-channel overflow output.

Top module: `tdc_capture_readout`

## Requirements
- R1: The counter starts at 0 after reset and adds 1 on every counting-clock edge. It is 9 bits wide and wraps from 511 to 0, and a hit stamped across the wrap reads back the wrapped value.
- R2: When a hit input rises while the counter holds N, the channel stores the timestamp (N+2) mod 512. The two counting-clock edges of delay come from the two-flop synchroniser.
- R3: A hit input that stays high produces exactly one capture, at its rising edge. It does not recapture and does not raise overflow while held.
- R4: ovf_o[c] goes to 1 when channel c captures while its previous value has not yet been loaded. It stays at 1 until reset. A capture after the previous value has been loaded leaves it at 0.
- R5: A second capture before a load replaces the first, and the next readout returns the newer timestamp.
- R6: A readout edge with mode_i = 0 loads every channel's register. On the following edges with mode_i = 1, ser_o[c] presents timestamp bit 8 first, then bits 7 down to 0, one bit per readout cycle, followed by zeros.
- R7: After a load, frame_vld_o is high for exactly the nine readout cycles that carry bits 8..0 (with mode_i held at 1), and it is low otherwise. A load during a frame restarts the frame from bit 8.
- R8: Channels are independent. Each readout returns the latest timestamp of every channel once the crossing has settled (about ten readout cycles). Hits on several channels in the same counting cycle give identical timestamps.
- R9: Reset clears all state. While reset is high and after it is released, ser_o, frame_vld_o and ovf_o are 0, and a readout with no hits returns 0 on every channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_cnt | input | 1 | Counting clock for the counter, synchronisers and capture |
| clk_rd | input | 1 | Readout clock that paces loading and shifting |
| rst | input | 1 | Synchronous active-high reset, held for several cycles of both clocks |
| hit_i | input | NUM_CH (8) | Discriminator hit inputs, one per channel |
| mode_i | input | 1 | Readout mode: 0 loads the registers, 1 shifts them |
| ser_o | output | NUM_CH (8) | Serial timestamp data, one line per channel, MSB first |
| frame_vld_o | output | 1 | High during the nine data cycles after a load |
| ovf_o | output | NUM_CH (8) | Sticky per-channel overflow, in the counting domain |

## Verification
A reload and an ongoing shift can fall on the same readout edge. The bench drops mode_i to 0 after three bits of a frame have gone out, then checks that frame_vld_o stays high for a fresh run of nine cycles and that the serial line restarts from bit 8 of the same timestamp. Captures on all eight channels in one counting cycle are a second coincidence, and they must read back as one shared timestamp. The overflow flag is judged around a load: a repeated hit before the load must set it, while a hit after the load must not.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  // Readout register behaviour selected by the mode input
  typedef enum logic {
    MODE_LOAD  = 1'b0,
    MODE_SHIFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/tdc_free_counter.sv
module tdc_free_counter #(
  parameter int STAMP_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  output logic [STAMP_W-1:0] count_o
);
  // All bits update on the same edge; natural wrap at 2**STAMP_W
  always_ff @(posedge clk) begin
    if (rst) count_o <= '0;
    else     count_o <= count_o + 1'b1;
  end

  a_r1_count_step: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (count_o == $past(count_o) + 1'b1));
endmodule

// File: rtl/tdc_hit_front.sv
module tdc_hit_front #(
  parameter int STAMP_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hit_i,
  input  logic [STAMP_W-1:0] count_i,
  input  logic               ack_tgl_i,
  input  logic               load_tgl_i,
  output logic [STAMP_W-1:0] hold_o,
  output logic               req_tgl_o,
  output logic               ovf_o
);
  logic               sy1_q, sy2_q, prev_q;
  logic [STAMP_W-1:0] cap_q, hold_q;
  logic               vld_q, dirty_q, req_q, ovf_q;
  logic               ack_s1_q, ack_s2_q;
  logic               ld_s1_q, ld_s2_q, ld_s3_q;
  logic               rise, busy, load_seen, clear_ok;

  assign rise      = sy2_q & ~prev_q;
  assign busy      = req_q ^ ack_s2_q;
  assign load_seen = ld_s2_q ^ ld_s3_q;
  // A load only consumes the pending value if the far side already holds it
  assign clear_ok  = load_seen & ~dirty_q & ~busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      sy1_q <= 1'b0; sy2_q <= 1'b0; prev_q <= 1'b0;
      cap_q <= '0; hold_q <= '0;
      vld_q <= 1'b0; dirty_q <= 1'b0; req_q <= 1'b0; ovf_q <= 1'b0;
      ack_s1_q <= 1'b0; ack_s2_q <= 1'b0;
      ld_s1_q <= 1'b0; ld_s2_q <= 1'b0; ld_s3_q <= 1'b0;
    end else begin
      sy1_q    <= hit_i;
      sy2_q    <= sy1_q;
      prev_q   <= sy2_q;
      ack_s1_q <= ack_tgl_i;
      ack_s2_q <= ack_s1_q;
      ld_s1_q  <= load_tgl_i;
      ld_s2_q  <= ld_s1_q;
      ld_s3_q  <= ld_s2_q;
      if (rise) begin
        cap_q   <= count_i;
        vld_q   <= 1'b1;
        dirty_q <= 1'b1;
        if (vld_q && !clear_ok) ovf_q <= 1'b1;
      end else begin
        if (clear_ok) vld_q <= 1'b0;
        if (dirty_q && !busy) begin
          hold_q  <= cap_q;
          req_q   <= ~req_q;
          dirty_q <= 1'b0;
        end
      end
    end
  end

  assign hold_o    = hold_q;
  assign req_tgl_o = req_q;
  assign ovf_o     = ovf_q;

  a_r2_capture_value: assert property (@(posedge clk) disable iff (rst)
    rise |=> (cap_q == $past(count_i)));
  a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> ovf_q);
  a_r8_hold_stable: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(hold_q));
endmodule

// File: rtl/tdc_ser_lane.sv
module tdc_ser_lane #(
  parameter int STAMP_W = 9
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [STAMP_W-1:0] hold_i,
  input  logic               req_tgl_i,
  output logic               ack_tgl_o,
  output logic               load_tgl_o,
  output logic               ser_o
);
  logic               rq_s1_q, rq_s2_q, rq_s3_q;
  logic [STAMP_W-1:0] mirror_q, sreg_q;
  logic               ld_tgl_q;
  logic               arrive;

  assign arrive = rq_s2_q ^ rq_s3_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rq_s1_q <= 1'b0; rq_s2_q <= 1'b0; rq_s3_q <= 1'b0;
      mirror_q <= '0; sreg_q <= '0; ld_tgl_q <= 1'b0;
    end else begin
      rq_s1_q <= req_tgl_i;
      rq_s2_q <= rq_s1_q;
      rq_s3_q <= rq_s2_q;
      if (arrive) mirror_q <= hold_i;
      if (load_i) begin
        // A value arriving on the load edge is taken directly
        sreg_q   <= arrive ? hold_i : mirror_q;
        ld_tgl_q <= ~ld_tgl_q;
      end else begin
        sreg_q <= {sreg_q[STAMP_W-2:0], 1'b0};
      end
    end
  end

  assign ack_tgl_o  = rq_s3_q;
  assign load_tgl_o = ld_tgl_q;
  assign ser_o      = sreg_q[STAMP_W-1];
endmodule

// File: rtl/tdc_frame_seq.sv
module tdc_frame_seq
  import tdc_pkg::*;
#(
  parameter int STAMP_W = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic mode_i,
  output logic load_o,
  output logic frame_vld_o
);
  localparam int FCW = $clog2(STAMP_W + 1);

  logic [FCW-1:0] fcnt_q, fcnt_n;
  logic           frame_q;

  assign load_o = (mode_i == MODE_LOAD);

  always_comb begin
    if (load_o)            fcnt_n = FCW'(STAMP_W);
    else if (fcnt_q != '0) fcnt_n = fcnt_q - 1'b1;
    else                   fcnt_n = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt_q  <= '0;
      frame_q <= 1'b0;
    end else begin
      fcnt_q  <= fcnt_n;
      frame_q <= (fcnt_n != '0);
    end
  end

  assign frame_vld_o = frame_q;

  a_r7_frame_after_load: assert property (@(posedge clk) disable iff (rst)
    load_o |=> frame_vld_o);
  a_r7_frame_stays_low: assert property (@(posedge clk) disable iff (rst)
    (!frame_vld_o && !load_o) |=> !frame_vld_o);
endmodule

// File: rtl/tdc_capture_readout.sv
module tdc_capture_readout #(
  parameter int NUM_CH  = 8,
  parameter int STAMP_W = 9
) (
  input  logic              clk_cnt,
  input  logic              clk_rd,
  input  logic              rst,
  input  logic [NUM_CH-1:0] hit_i,
  input  logic              mode_i,
  output logic [NUM_CH-1:0] ser_o,
  output logic              frame_vld_o,
  output logic [NUM_CH-1:0] ovf_o
);
  logic [STAMP_W-1:0]             count;
  logic [NUM_CH-1:0][STAMP_W-1:0] hold_w;
  logic [NUM_CH-1:0]              req_w, ack_w, ldt_w;
  logic                           load_w;

  tdc_free_counter #(.STAMP_W(STAMP_W)) u_counter (
    .clk     (clk_cnt),
    .rst     (rst),
    .count_o (count)
  );

  tdc_frame_seq #(.STAMP_W(STAMP_W)) u_frame (
    .clk         (clk_rd),
    .rst         (rst),
    .mode_i      (mode_i),
    .load_o      (load_w),
    .frame_vld_o (frame_vld_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tdc_hit_front #(.STAMP_W(STAMP_W)) u_front (
      .clk        (clk_cnt),
      .rst        (rst),
      .hit_i      (hit_i[c]),
      .count_i    (count),
      .ack_tgl_i  (ack_w[c]),
      .load_tgl_i (ldt_w[c]),
      .hold_o     (hold_w[c]),
      .req_tgl_o  (req_w[c]),
      .ovf_o      (ovf_o[c])
    );

    tdc_ser_lane #(.STAMP_W(STAMP_W)) u_lane (
      .clk        (clk_rd),
      .rst        (rst),
      .load_i     (load_w),
      .hold_i     (hold_w[c]),
      .req_tgl_i  (req_w[c]),
      .ack_tgl_o  (ack_w[c]),
      .load_tgl_o (ldt_w[c]),
      .ser_o      (ser_o[c])
    );
  end
endmodule

// File: tb/tdc_capture_readout_tb.sv
module tdc_capture_readout_tb;
  localparam int CNT_PERIOD = 10;
  localparam int RD_PERIOD  = 26;
  localparam int NCH        = 8;
  localparam int W          = 9;

  logic           clk_cnt = 1'b0;
  logic           clk_rd  = 1'b0;
  logic           rst     = 1'b1;
  logic [NCH-1:0] hit     = '0;
  logic           mode    = 1'b1;
  logic [NCH-1:0] ser, ovf;
  logic           fvld;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] tb_cnt;
  logic [W-1:0] got [NCH];
  logic [W-1:0] expv [NCH];

  always #(CNT_PERIOD/2) clk_cnt = ~clk_cnt;
  always #(RD_PERIOD/2)  clk_rd  = ~clk_rd;

  // Model of R1: zero in reset, +1 per counting edge, natural wrap
  always @(posedge clk_cnt) tb_cnt <= rst ? '0 : tb_cnt + 1'b1;

  tdc_capture_readout #(.NUM_CH(NCH), .STAMP_W(W)) u_dut (
    .clk_cnt     (clk_cnt),
    .clk_rd      (clk_rd),
    .rst         (rst),
    .hit_i       (hit),
    .mode_i      (mode),
    .ser_o       (ser),
    .frame_vld_o (fvld),
    .ovf_o       (ovf)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic hit_mask(input logic [NCH-1:0] m, input int hold, output logic [W-1:0] stamp);
    @(negedge clk_cnt);
    stamp = tb_cnt + 9'd2;
    hit = hit | m;
    repeat (hold) @(negedge clk_cnt);
    hit = hit & ~m;
    repeat (3) @(negedge clk_cnt);
  endtask

  task automatic settle();
    repeat (12) @(negedge clk_rd);
  endtask

  // Called at the negedge right after the load edge, with mode just set to 1
  task automatic collect(input string req);
    int bad = 0;
    for (int i = 0; i < W; i++) begin
      if (fvld !== 1'b1) bad++;
      for (int c = 0; c < NCH; c++) got[c][W-1-i] = ser[c];
      if (i < W-1) @(negedge clk_rd);
    end
    chk({req, " frame high 9 cycles"}, bad, 0);
    @(negedge clk_rd);
    chk({req, " frame low after bit 0"}, fvld, 0);
  endtask

  task automatic read_frame(input string req);
    @(negedge clk_rd); mode = 1'b0;
    @(negedge clk_rd); mode = 1'b1;
    collect(req);
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk_rd);
    chk("R9 ser in reset", ser, 0);
    chk("R9 frame in reset", fvld, 0);
    chk("R9 ovf in reset", ovf, 0);
    @(negedge clk_cnt); rst = 1'b0;
    repeat (3) @(negedge clk_rd);
    chk("R9 ser after reset", ser, 0);
    chk("R9 frame after reset", fvld, 0);
    read_frame("R9");
    for (int c = 0; c < NCH; c++) chk("R9 empty readout", got[c], 0);
    chk("R9 ovf after reset", ovf, 0);
  endtask

  task automatic t_single();
    logic [W-1:0] s;
    hit_mask(8'h04, 2, s);
    settle();
    read_frame("R6");
    chk("R2 R6 ch2 timestamp MSB first", got[2], s);
    chk("R8 ch1 untouched", got[1], 0);
    chk("R4 no overflow", ovf, 0);
  endtask

  task automatic t_stagger();
    for (int c = 0; c < NCH; c++) begin
      logic [W-1:0] s;
      hit_mask(NCH'(1) << c, 2 + c, s);
      expv[c] = s;
      repeat (c) @(negedge clk_cnt);
    end
    settle();
    read_frame("R8");
    for (int c = 0; c < NCH; c++) chk("R8 staggered channel", got[c], expv[c]);
    chk("R4 hit after load no overflow", ovf, 0);
  endtask

  task automatic t_same_cycle();
    logic [W-1:0] s;
    hit_mask('1, 3, s);
    settle();
    read_frame("R8");
    for (int c = 0; c < NCH; c++) chk("R8 same-cycle stamp", got[c], s);
  endtask

  task automatic t_held();
    logic [W-1:0] s;
    @(negedge clk_cnt);
    s = tb_cnt + 9'd2;
    hit[1] = 1'b1;
    repeat (40) @(negedge clk_cnt);
    settle();
    read_frame("R3");
    chk("R3 held input single capture", got[1], s);
    chk("R3 held input no overflow", ovf[1], 0);
    @(negedge clk_cnt); hit[1] = 1'b0;
    repeat (4) @(negedge clk_cnt);
  endtask

  task automatic t_wrap();
    logic [W-1:0] s4;
    do @(negedge clk_cnt); while (tb_cnt != 9'd510);
    hit[5] = 1'b1;
    @(negedge clk_cnt);
    s4 = tb_cnt + 9'd2;
    hit[4] = 1'b1;
    repeat (3) @(negedge clk_cnt);
    hit[5] = 1'b0; hit[4] = 1'b0;
    settle();
    read_frame("R1");
    chk("R1 wrap 510+2", got[5], 0);
    chk("R1 wrap 511+2", got[4], 1);
    chk("R1 s4 model", s4, 1);
  endtask

  task automatic t_ovf();
    logic [W-1:0] s1, s2, s3;
    hit_mask(8'h40, 2, s1);
    chk("R4 first hit no overflow", ovf[6], 0);
    hit_mask(8'h40, 2, s2);
    chk("R4 repeat hit overflow", ovf[6], 1);
    chk("R4 other channel clear", ovf[3], 0);
    settle();
    read_frame("R5");
    chk("R5 newer value kept", got[6], s2);
    hit_mask(8'h08, 2, s3);
    settle();
    chk("R4 hit after load keeps flag low", ovf[3], 0);
    chk("R4 overflow sticky", ovf[6], 1);
    read_frame("R8");
    chk("R8 ch3 after overflow test", got[3], s3);
    if (s1 == s2) chk("R5 distinct stamps", 0, 1);
  endtask

  task automatic t_reload();
    logic [W-1:0] s;
    hit_mask(8'h01, 2, s);
    settle();
    @(negedge clk_rd); mode = 1'b0;
    @(negedge clk_rd); mode = 1'b1;
    chk("R6 bit 8 first", ser[0], s[8]);
    repeat (3) @(negedge clk_rd);
    chk("R6 bit 5 after three shifts", ser[0], s[5]);
    mode = 1'b0;
    @(negedge clk_rd); mode = 1'b1;
    collect("R7 reload");
    chk("R7 reload restarts from bit 8", got[0], s);
  endtask

  initial begin
    t_reset();
    t_single();
    t_stagger();
    t_same_cycle();
    t_held();
    t_wrap();
    t_ovf();
    t_reload();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CNT_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule